// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block chooses which of 22 interrupt sources a small CPU should take next. Each cycle it looks at the pending flags, the per-source enables, the per-source level bits and a global enable. It picks one winner, then presents a registered request to the CPU together with the winner's source number and its entry address.

There are two levels. A low-level handler can be interrupted by a high-level request. A high-level handler is never interrupted. When several sources compete, the lowest source number wins within a level. To apply these rules the block keeps one in-service bit per level.

The CPU drives three inputs:
- an acknowledge when it starts servicing the presented request;
- a pulse when it executes a return from interrupt;
- a pulse at every instruction boundary.

After a return, no new request is presented until one more instruction boundary has passed. Running the handler, clearing the source flags and the call sequence are done outside this block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `req_o` is 0 and `insvc_o` is 2'b00. Every level bit defaults to 0, which means low.
- R2: When `gie_i` is 0, no request is presented, whatever the pending and enable bits are.
- R3: A masked source is one whose pending and enable bits are both 1, with `gie_i` = 1. Among masked sources, one with level bit 1 (high) wins over any with level bit 0 (low). Within a level, the lowest index wins.
- R4: While `req_o` is 1, `vec_o` equals 16'h0003 + 8 × `idx_o`. For example, index 21 gives 16'h00AB.
- R5: While the high in-service bit (`insvc_o[1]`) is set, no request is presented. While only the low bit (`insvc_o[0]`) is set, only high-level sources can be requested.
- R6: A request at an allowed level shows on `req_o` one clock edge after the pending input is sampled.
- R7: When `ack_i` is 1 while `req_o` is 1, `req_o` drops on the next edge. On the same edge, the in-service bit of the presented level (`req_lvl_o`) is set.
- R8: A pulse on `reti_i` clears `insvc_o[1]` if it is set. Otherwise it clears `insvc_o[0]`.
- R9: From a return until the edge on which `instr_done_i` is sampled high, no request is presented. A request can appear on the edge after that one at the earliest.
- R10: A presented request keeps its index and vector for as long as its source stays masked, keeps its level and stays allowed. This holds even if a higher-ranked source starts pending meanwhile. If the presented source drops out, the block presents the next winner.
- R11: An `ack_i` pulse while `req_o` is 0 leaves `insvc_o` unchanged.
- R12: A pending source whose enable bit is 0 never causes a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | 22 | Pending flag per source |
| en_i | input | 22 | Enable bit per source |
| lvl_i | input | 22 | Level per source, 1 = high |
| gie_i | input | 1 | Global enable |
| ack_i | input | 1 | CPU starts servicing the presented request |
| reti_i | input | 1 | CPU executes a return from interrupt |
| instr_done_i | input | 1 | CPU instruction boundary |
| req_o | output | 1 | Request to the CPU |
| idx_o | output | 5 | Index of the presented source |
| vec_o | output | 16 | Entry address of the presented source |
| req_lvl_o | output | 1 | Level of the presented source |
| insvc_o | output | 2 | In-service bits, [1] high, [0] low |

## Verification
The bench builds the block with its defaults: 22 sources, a 16-bit address, base 3 and stride 8. With these values the highest index, 21, and its 16'h00AB vector are reachable. Sparse random pending vectors over the full width exercise lowest-index selection across both levels. Random acknowledge and return pulses drive both in-service bits through nesting, including the window after a return.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } prio_lvl_e;

    localparam int unsigned NUM_LEVELS = 2;

    // Entry address of a source: base plus stride times index.
    function automatic logic [31:0] entry_addr(input logic [31:0] base,
                                               input logic [31:0] stride,
                                               input logic [31:0] index);
        return base + stride * index;
    endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned N    = 22,
    localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    // The scan runs downward, so the lowest set index is assigned last and wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_prio_svc.sv
module irq_prio_svc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       grant_i,
    input  logic       grant_lvl_i,
    input  logic       ret_i,
    input  logic       boundary_i,
    output logic [1:0] insvc_o,
    output logic       hold_o
);
    import irq_prio_pkg::*;

    typedef struct packed {
        logic [NUM_LEVELS-1:0] insvc;
        logic                  hold;
    } svc_t;

    svc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ret_i) begin
            // Return from the innermost handler.
            if (st_q.insvc[LVL_HIGH]) begin
                st_d.insvc[LVL_HIGH] = 1'b0;
            end else begin
                st_d.insvc[LVL_LOW] = 1'b0;
            end
            st_d.hold = 1'b1;
        end else if (boundary_i) begin
            st_d.hold = 1'b0;
        end
        if (grant_i) begin
            st_d.insvc[grant_lvl_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign insvc_o = st_q.insvc;
    assign hold_o  = st_q.hold;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int unsigned NUM_SRC    = 22,
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned VEC_BASE   = 3,
    parameter int unsigned VEC_STRIDE = 8,
    localparam int unsigned IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] lvl_i,
    input  logic               gie_i,
    input  logic               ack_i,
    input  logic               reti_i,
    input  logic               instr_done_i,
    output logic               req_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [ADDR_W-1:0]  vec_o,
    output logic               req_lvl_o,
    output logic [1:0]         insvc_o
);
    import irq_prio_pkg::*;

    typedef struct packed {
        logic              req;
        logic              lvl;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] vec;
    } out_t;

    out_t out_d, out_q;

    logic [NUM_SRC-1:0] masked;
    logic [NUM_LEVELS-1:0] lvl_found;
    logic [IDX_W-1:0]      lvl_idx [NUM_LEVELS];
    logic [1:0]            insvc;
    logic                  hold;
    logic                  grant;

    assign masked = pend_i & en_i & {NUM_SRC{gie_i}};

    // One lowest-index picker per level.
    generate
        for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
            logic [NUM_SRC-1:0] lvl_cand;
            assign lvl_cand = (g == LVL_HIGH) ? (masked & lvl_i) : (masked & ~lvl_i);
            irq_prio_pick #(.N(NUM_SRC)) u_pick (
                .cand_i  (lvl_cand),
                .found_o (lvl_found[g]),
                .idx_o   (lvl_idx[g])
            );
        end
    endgenerate

    assign grant = ack_i & out_q.req;

    irq_prio_svc u_svc (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_i     (grant),
        .grant_lvl_i (out_q.lvl),
        .ret_i       (reti_i),
        .boundary_i  (instr_done_i),
        .insvc_o     (insvc),
        .hold_o      (hold)
    );

    // A level may be requested when nothing at its level or above is in service
    // and no return is in progress.
    function automatic logic level_ok(input logic lvl, input logic [1:0] svc,
                                      input logic hld, input logic ret);
        return !ret && !hld && !svc[LVL_HIGH] && (lvl || !svc[LVL_LOW]);
    endfunction

    logic             cand_valid;
    logic             cand_lvl;
    logic [IDX_W-1:0] cand_idx;
    logic             keep;

    always_comb begin
        cand_valid = lvl_found[LVL_HIGH] | lvl_found[LVL_LOW];
        cand_lvl   = lvl_found[LVL_HIGH];
        cand_idx   = lvl_found[LVL_HIGH] ? lvl_idx[LVL_HIGH] : lvl_idx[LVL_LOW];
        keep       = out_q.req && masked[out_q.idx] && (lvl_i[out_q.idx] == out_q.lvl)
                     && level_ok(out_q.lvl, insvc, hold, reti_i);

        out_d = out_q;
        if (grant) begin
            out_d.req = 1'b0;
        end else if (keep) begin
            out_d = out_q;
        end else if (cand_valid && level_ok(cand_lvl, insvc, hold, reti_i)) begin
            out_d.req = 1'b1;
            out_d.lvl = cand_lvl;
            out_d.idx = cand_idx;
            out_d.vec = ADDR_W'(entry_addr(VEC_BASE, VEC_STRIDE, 32'(cand_idx)));
        end else begin
            out_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign req_o     = out_q.req;
    assign idx_o     = out_q.idx;
    assign vec_o     = out_q.vec;
    assign req_lvl_o = out_q.lvl;
    assign insvc_o   = insvc;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int unsigned NUM_SRC    = 22,
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned VEC_BASE   = 3,
    parameter int unsigned VEC_STRIDE = 8,
    localparam int unsigned IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] pend_i,
    input logic [NUM_SRC-1:0] en_i,
    input logic [NUM_SRC-1:0] lvl_i,
    input logic               gie_i,
    input logic               ack_i,
    input logic               reti_i,
    input logic               instr_done_i,
    input logic               req_o,
    input logic [IDX_W-1:0]   idx_o,
    input logic [ADDR_W-1:0]  vec_o,
    input logic               req_lvl_o,
    input logic [1:0]         insvc_o
);

    p_gie_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |=> !req_o);

    p_vec_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (vec_o == ADDR_W'(VEC_BASE + VEC_STRIDE * idx_o)));

    p_high_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        insvc_o[1] |-> !req_o);

    p_ack_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i && !reti_i) |=> (!req_o && insvc_o[$past(req_lvl_o)]));

    p_ret_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && insvc_o[1] && !(ack_i && req_o)) |=>
        (!insvc_o[1] && insvc_o[0] == $past(insvc_o[0])));

    p_ret_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> !req_o);

    p_idle_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && ack_i && !reti_i) |=> (insvc_o == $past(insvc_o)));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NUM_SRC    (NUM_SRC),
    .ADDR_W     (ADDR_W),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
) u_chk (.*);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
    localparam int N  = 22;
    localparam int IW = 5;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pend_i = '0, en_i = '0, lvl_i = '0;
    logic          gie_i = 1'b0, ack_i = 1'b0, reti_i = 1'b0, instr_done_i = 1'b0;
    logic          req_o, req_lvl_o;
    logic [IW-1:0] idx_o;
    logic [AW-1:0] vec_o;
    logic [1:0]    insvc_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (.*);

    // Reference model, written from the requirements.
    logic          m_req, m_lvl, m_hold;
    logic [IW-1:0] m_idx;
    logic [1:0]    m_svc;

    function automatic logic lvl_allowed(input logic l, input logic [1:0] s,
                                         input logic h, input logic r);
        return !r && !h && !s[1] && (l || !s[0]);
    endfunction

    function automatic logic [AW-1:0] exp_vec(input logic [IW-1:0] i);
        return AW'(16'h0003 + 16'(i) * 16'd8);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_req <= 0; m_lvl <= 0; m_idx <= 0; m_svc <= 0; m_hold <= 0;
        end else begin
            logic [N-1:0] mk;
            logic [1:0]   ns;
            logic         found, fl;
            logic [IW-1:0] fi;
            mk = pend_i & en_i & {N{gie_i}};
            found = 0; fl = 0; fi = 0;
            for (int l = 1; l >= 0; l--)
                if (!found)
                    for (int i = 0; i < N; i++)
                        if (!found && mk[i] && lvl_i[i] == l[0]) begin
                            found = 1; fl = l[0]; fi = IW'(i);
                        end
            ns = m_svc;
            if (reti_i) begin
                if (ns[1]) ns[1] = 0; else ns[0] = 0;
            end
            if (ack_i && m_req) ns[m_lvl] = 1;
            m_svc  <= ns;
            m_hold <= reti_i ? 1'b1 : (instr_done_i ? 1'b0 : m_hold);
            if (ack_i && m_req) m_req <= 0;
            else if (m_req && mk[m_idx] && lvl_i[m_idx] == m_lvl &&
                     lvl_allowed(m_lvl, m_svc, m_hold, reti_i)) m_req <= 1;
            else if (found && lvl_allowed(fl, m_svc, m_hold, reti_i)) begin
                m_req <= 1; m_lvl <= fl; m_idx <= fi;
            end else m_req <= 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R3, R5, R6, R9, R10, R12).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 req vs model", 32'(req_o), 32'(m_req));
            chk("R8 insvc vs model", 32'(insvc_o), 32'(m_svc));
            if (m_req && req_o) begin
                chk("R3 idx vs model", 32'(idx_o), 32'(m_idx));
                chk("R5 lvl vs model", 32'(req_lvl_o), 32'(m_lvl));
                chk("R4 vec vs model", 32'(vec_o), 32'(exp_vec(m_idx)));
            end
        end
    end

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0; pend_i = '0; en_i = '1; lvl_i = '0; gie_i = 1;
        ack_i = 0; reti_i = 0; instr_done_i = 0;
        tick(2);
        rst_n = 1;
        tick(1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        chk("R1 req after reset", 32'(req_o), 0);
        chk("R1 insvc after reset", 32'(insvc_o), 0);

        // R2: global enable off
        gie_i = 0; pend_i = N'(1) << 3;
        tick(2);
        chk("R2 no req with gie=0", 32'(req_o), 0);
        gie_i = 1;
        tick(1);
        chk("R6 req one edge later", 32'(req_o), 1);
        chk("R4 idx 3", 32'(idx_o), 3);
        chk("R4 vec idx 3", 32'(vec_o), 32'h1B);

        // R10: newcomers do not displace the presented request
        lvl_i[10] = 1; lvl_i[12] = 1;
        pend_i = pend_i | (N'(1) << 10) | (N'(1) << 12);
        tick(1);
        chk("R10 held idx", 32'(idx_o), 3);
        pend_i[3] = 0;
        tick(1);
        chk("R3 high lowest idx", 32'(idx_o), 10);
        chk("R3 high level", 32'(req_lvl_o), 1);

        // R7: acknowledge
        ack_i = 1; tick(1); ack_i = 0;
        chk("R7 req dropped", 32'(req_o), 0);
        chk("R7 high in service", 32'(insvc_o), 2);
        tick(1);
        chk("R5 high not preempted", 32'(req_o), 0);

        // R8/R9: return then one boundary
        reti_i = 1; tick(1); reti_i = 0;
        chk("R8 high cleared", 32'(insvc_o), 0);
        chk("R9 no req after return", 32'(req_o), 0);
        tick(2);
        chk("R9 still held", 32'(req_o), 0);
        instr_done_i = 1; tick(1); instr_done_i = 0;
        chk("R9 held on boundary edge", 32'(req_o), 0);
        tick(1);
        chk("R9 req after boundary", 32'(req_o), 1);
        chk("R9 idx after boundary", 32'(idx_o), 10);

        // Low in service, equal level waits, high preempts
        do_reset();
        pend_i = N'(1) << 21;
        tick(1);
        chk("R4 idx 21", 32'(idx_o), 21);
        chk("R4 vec idx 21", 32'(vec_o), 32'hAB);
        ack_i = 1; tick(1); ack_i = 0;
        chk("R7 low in service", 32'(insvc_o), 1);
        pend_i[2] = 1;
        tick(2);
        chk("R5 equal level waits", 32'(req_o), 0);
        lvl_i[15] = 1; pend_i[15] = 1;
        tick(1);
        chk("R5 high preempts low", 32'(req_o), 1);
        chk("R5 preempt idx", 32'(idx_o), 15);
        ack_i = 1; tick(1); ack_i = 0;
        chk("R7 both in service", 32'(insvc_o), 3);
        pend_i = '0;
        reti_i = 1; tick(1); reti_i = 0;
        chk("R8 high cleared first", 32'(insvc_o), 1);
        instr_done_i = 1; tick(1); instr_done_i = 0;
        reti_i = 1; tick(1); reti_i = 0;
        chk("R8 low cleared", 32'(insvc_o), 0);

        // R11: stray acknowledge
        do_reset();
        ack_i = 1; tick(1); ack_i = 0;
        chk("R11 stray ack insvc", 32'(insvc_o), 0);
        chk("R11 stray ack req", 32'(req_o), 0);

        // R12: disabled source
        en_i[4] = 0; pend_i = N'(1) << 4;
        tick(2);
        chk("R12 disabled source", 32'(req_o), 0);

        // Random phase
        do_reset();
        for (int c = 0; c < 4000; c++) begin
            logic r_ack, r_ret;
            pend_i = N'($urandom & $urandom & $urandom);
            en_i   = ~N'($urandom & $urandom & $urandom);
            lvl_i  = N'($urandom);
            gie_i  = ($urandom % 10) != 0;
            r_ack  = req_o ? (($urandom % 3) == 0) : (($urandom % 16) == 0);
            r_ret  = !r_ack && (insvc_o != 0) && (($urandom % 5) == 0);
            ack_i  = r_ack;
            reti_i = r_ret;
            instr_done_i = ($urandom % 2) == 0;
            tick(1);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule